// File: doc/BRIEF.md
# System Control Port for Counter Channel 2

This block is an 8-bit control and status port that sits beside a programmable interval counter. Software writes it to open or close the gate of counter channel 2 and to switch the speaker data path on or off. Software reads it to see those two settings, the live output of channel 2 and a slowly toggling refresh indicator that old software polls as a coarse time base.

The refresh indicator comes from a fixed divider running on the system clock. Its half-period in clock cycles is a parameter; at a 250 MHz clock, 4096 cycles give a half-period of about 16 µs. A write that opens the gate while it was closed also produces a single-cycle rising-edge pulse toward channel 2, so that the counter can restart its count on the edge.

Top module: `sysctl_port`

## Requirements
- R1: One cycle after a write (`wr_en` high at a clock edge), `ch2_gate` equals bit 0 of the written byte.
- R2: One cycle after a write, `spk_data_en` equals bit 1 of the written byte.
- R3: `rd_data` bit 0 always shows the current `ch2_gate` and bit 1 shows the current `spk_data_en`.
- R4: `rd_data` bit 5 follows `ch2_out` in the same cycle, with no register in the path.
- R5: `rd_data` bit 4 is the refresh bit: it reads 0 after reset, and it inverts every `REFRESH_HALF` clock edges, the first inversion on the `REFRESH_HALF`-th edge after reset is released.
- R6: `rd_data` bits 2, 3, 6 and 7 always read 0, and the values written into bits 2 to 7 have no effect on any output.
- R7: While `rst` is high, `ch2_gate`, `spk_data_en`, `ch2_gate_rise` and the refresh bit are 0.
- R8: `ch2_gate_rise` is high for exactly one cycle, the same cycle in which `ch2_gate` first reads 1, when a write sets bit 0 while the gate was 0; a write of bit 0 = 1 with the gate already 1 gives no pulse.
- R9: Without a write, `ch2_gate` and `spk_data_en` keep their values whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Byte written to the port |
| ch2_out | input | 1 | Output of counter channel 2 |
| rd_data | output | 8 | Status byte read from the port |
| ch2_gate | output | 1 | Gate level for counter channel 2 |
| ch2_gate_rise | output | 1 | One-cycle pulse on a gate 0-to-1 write |
| spk_data_en | output | 1 | Speaker data enable |

## Verification
The write path is driven with a sequence of bytes that walks the gate and speaker bits through all four combinations from both previous states, so that a gate write with the gate already open is told apart from one that opens it, and a pulse that fires on any set bit 0 is caught. Several bytes carry ones in the unused upper and middle bits, which tells a correct field decode apart from one that leaks those bits into the status byte or the controls. The channel 2 output is toggled both together with writes and with no write pending, which separates a direct pass-through from a registered one. The refresh bit is sampled on the edges just before and just on each expected inversion, which exposes an off-by-one in the divider.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int PORT_W      = 8;
    localparam int BIT_GATE    = 0;
    localparam int BIT_SPK     = 1;
    localparam int BIT_REFRESH = 4;
    localparam int BIT_OUT     = 5;

    // writable controls held by the port
    typedef struct packed {
        logic spk_en;
        logic gate;
    } ctl_bits_t;

    // every source that feeds the status byte
    typedef struct packed {
        ctl_bits_t ctl;
        logic      refresh;
        logic      ch2_out;
    } status_src_t;

    function automatic ctl_bits_t decode_write(input logic [PORT_W-1:0] d);
        ctl_bits_t c;
        c.gate   = d[BIT_GATE];
        c.spk_en = d[BIT_SPK];
        return c;
    endfunction

    function automatic logic pick_bit(input status_src_t s, input int pos);
        logic b;
        case (pos)
            BIT_GATE:    b = s.ctl.gate;
            BIT_SPK:     b = s.ctl.spk_en;
            BIT_REFRESH: b = s.refresh;
            BIT_OUT:     b = s.ch2_out;
            default:     b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sysctl_refresh_div.sv
module sysctl_refresh_div #(
    parameter int REFRESH_HALF = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic refresh
);
    localparam int CNT_W = (REFRESH_HALF > 1) ? $clog2(REFRESH_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tog_q <= ~tog_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign refresh = tog_q;
endmodule

// File: rtl/sysctl_ctl_reg.sv
module sysctl_ctl_reg
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output ctl_bits_t         ctl,
    output logic              gate_rise
);
    ctl_bits_t ctl_q;
    ctl_bits_t ctl_d;
    logic      rise_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d = decode_write(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            rise_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_d;
            rise_q <= ctl_d.gate & ~ctl_q.gate;
        end
    end

    assign ctl       = ctl_q;
    assign gate_rise = rise_q;
endmodule

// File: rtl/sysctl_status_mux.sv
module sysctl_status_mux
    import sysctl_pkg::*;
(
    input  status_src_t       src,
    output logic [PORT_W-1:0] status
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        assign status[i] = pick_bit(src, i);
    end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int REFRESH_HALF = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ch2_out,
    output logic [7:0] rd_data,
    output logic       ch2_gate,
    output logic       ch2_gate_rise,
    output logic       spk_data_en
);
    ctl_bits_t   ctl;
    logic        refresh;
    status_src_t src;

    sysctl_refresh_div #(.REFRESH_HALF(REFRESH_HALF)) u_div (
        .clk     (clk),
        .rst     (rst),
        .refresh (refresh)
    );

    sysctl_ctl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctl       (ctl),
        .gate_rise (ch2_gate_rise)
    );

    always_comb begin
        src.ctl     = ctl;
        src.refresh = refresh;
        src.ch2_out = ch2_out;
    end

    sysctl_status_mux u_mux (
        .src    (src),
        .status (rd_data)
    );

    assign ch2_gate    = ctl.gate;
    assign spk_data_en = ctl.spk_en;
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
    parameter int REFRESH_HALF = 4096
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       ch2_out,
    input logic [7:0] rd_data,
    input logic       ch2_gate,
    input logic       ch2_gate_rise,
    input logic       spk_data_en
);
    localparam int W = $clog2(REFRESH_HALF + 2) + 1;

    logic         prev_ref;
    logic [W-1:0] since_tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ref  <= 1'b0;
            since_tog <= '0;
        end else begin
            prev_ref  <= rd_data[4];
            since_tog <= (rd_data[4] != prev_ref) ? W'(1) : since_tog + 1'b1;
        end
    end

    AST_GATE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ch2_gate == $past(wr_data[0])); // R1
    AST_SPK_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> spk_data_en == $past(wr_data[1])); // R2
    AST_CTL_READBACK: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] == ch2_gate && rd_data[1] == spk_data_en); // R3
    AST_OUT_PASS: assert property (@(posedge clk) disable iff (rst)
        rd_data[5] == ch2_out); // R4
    AST_REFRESH_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (rd_data[4] != prev_ref) |-> since_tog == W'(REFRESH_HALF)); // R5
    AST_REFRESH_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
        since_tog <= W'(REFRESH_HALF)); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00); // R6
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ch2_gate_rise |=> !ch2_gate_rise); // R8
    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        ch2_gate_rise |-> ch2_gate && !$past(ch2_gate)); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ch2_gate) && $stable(spk_data_en)); // R9
endmodule

bind sysctl_port sysctl_port_chk #(.REFRESH_HALF(REFRESH_HALF)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .ch2_out       (ch2_out),
    .rd_data       (rd_data),
    .ch2_gate      (ch2_gate),
    .ch2_gate_rise (ch2_gate_rise),
    .spk_data_en   (spk_data_en)
);

// File: tb/sysctl_port_bench.sv
module sysctl_port_bench;
    localparam int HALF = 16;
    localparam int NVEC = 8;
    // {wr_data[7:0], ch2_out, expected rd_data with bit 4 masked [7:0], expected rise}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'h01, 1'b0, 8'h01, 1'b1},
        {8'h03, 1'b1, 8'h23, 1'b0},
        {8'h02, 1'b0, 8'h02, 1'b0},
        {8'hFD, 1'b1, 8'h21, 1'b1},
        {8'h00, 1'b0, 8'h00, 1'b0},
        {8'hFF, 1'b0, 8'h03, 1'b1},
        {8'hFE, 1'b1, 8'h22, 1'b0},
        {8'h01, 1'b0, 8'h01, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ch2_out = 1'b0;
    logic [7:0] rd_data;
    logic       ch2_gate, ch2_gate_rise, spk_data_en;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sysctl_port #(.REFRESH_HALF(HALF)) u_sysctl_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ch2_out(ch2_out), .rd_data(rd_data), .ch2_gate(ch2_gate),
        .ch2_gate_rise(ch2_gate_rise), .spk_data_en(spk_data_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R7: state while reset is held
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 reset rd_data", rd_data, 8'h00);
        check("R7 reset controls", {5'b0, ch2_gate, spk_data_en, ch2_gate_rise}, 8'h00);
        rst = 1'b0;

        // table walk: R1 R2 R3 R4 R6 R8
        for (int i = 0; i < NVEC; i++) begin
            wr_en = 1'b1; wr_data = VEC[i][17:10]; ch2_out = VEC[i][9];
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("R1 R2 R3 R4 R6 vec %0d", i), rd_data & 8'hEF, VEC[i][8:1]);
            check($sformatf("R1 gate vec %0d", i), {7'b0, ch2_gate}, {7'b0, VEC[i][1]});
            check($sformatf("R2 spk vec %0d", i), {7'b0, spk_data_en}, {7'b0, VEC[i][2]});
            check($sformatf("R8 pulse vec %0d", i), {7'b0, ch2_gate_rise}, {7'b0, VEC[i][0]});
            @(posedge clk); @(negedge clk);
            check($sformatf("R8 pulse ends vec %0d", i), {7'b0, ch2_gate_rise}, 8'h00);
        end

        // R9: no write, busy data bus; gate=1 spk=0 from last vector
        wr_data = 8'h02;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 hold gate/spk", {6'b0, spk_data_en, ch2_gate}, 8'h01);
        check("R9 no pulse without write", {7'b0, ch2_gate_rise}, 8'h00);

        // R4: output follows with no write pending, same cycle
        ch2_out = 1'b1; #1;
        check("R4 out high", {7'b0, rd_data[5]}, 8'h01);
        ch2_out = 1'b0; #1;
        check("R4 out low", {7'b0, rd_data[5]}, 8'h00);

        // R6: only upper bits written, controls unchanged
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hFD;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        check("R6 upper bits ignored", rd_data & 8'hEF, 8'h01);
        check("R8 no pulse when gate already 1", {7'b0, ch2_gate_rise}, 8'h00);

        // R7: reset with controls set
        wr_en = 1'b1; wr_data = 8'h03;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7 reset clears", {5'b0, ch2_gate, spk_data_en, rd_data[4]}, 8'h00);

        // R5: refresh timing from reset release
        do_reset();
        for (int k = 1; k <= 2 * HALF; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == HALF - 1 || k == HALF || k == 2 * HALF - 1 || k == 2 * HALF)
                check($sformatf("R5 refresh edge %0d", k), {7'b0, rd_data[4]},
                      {7'b0, 1'((k / HALF) % 2)});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule